// File: doc/BRIEF.md
# Clock Source Select, Divide and Gate Cell

This cell derives one output clock from a set of candidate sources. A two-level source selection picks either a primary reference or one of eight secondary sources. A 3-bit field chooses which secondary source is used. The chosen source then takes one of three paths to the output: a programmable divider whose ratio comes from a small non-linear table, a fixed divide-by-3 path that overrides every other setting, or a straight bypass. An enable bit gates the result.

All sources are modelled as single-cycle clock-enable ticks in the system clock domain, and one tick stands for one source period. The output comes in two forms. `clk_pulse` is a one-cycle strobe at the start of each output period. `clk_level` is a registered level that is high for the first part of each period. Software programs the cell through a small register port with a write enable and an address. The index, divider and gate fields can all be read back. Parameters can remove the source mux or the gate for instances that need a fixed source or an always-on clock.

Top module: `clk_seldiv_cell`

## Requirements
- R1: Writing logical source index 0 to address 0 (bits [3:0]) routes the primary reference. Writing an index N from 1 to 8 routes secondary source N-1, and the output period then equals the ratio times that source's period.
- R2: Reading address 0 returns 0 in bits [3:0] when the reference is selected, and 1 plus the secondary select field otherwise, so the value read matches the index written for 0 to 8.
- R3: With address 1 bit 1 (divide-by-3 switch) clear and bit 0 (divider switch) set, the divide code in bits [6:4] gives ratios 1, 2, 4, 6, 8, 12, 1, 1 for codes 0 to 7.
- R4: With the divide-by-3 switch set, the ratio is 3 whatever the divider switch and code. The level is high for 1 source period and low for 2.
- R5: With both switches clear, the ratio is 1 whatever the code, and `clk_level` stays high.
- R6: For even ratios, `clk_level` is high for exactly half of each output period.
- R7: Address 2 bit 0 is the gate. While it is 0, `clk_pulse` and `clk_level` are both low. While it is 1, the clock passes. The bit reads back as written.
- R8: A change of ratio or path takes effect at the next output period boundary: the period already running completes with the old ratio, and the divider restarts from zero.
- R9: After reset the source index, both switches, the code and the gate all read 0, and no output pulse appears.
- R10: With the mux parameter off, the cell always uses the reference and the index reads 0. With the gate parameter off, the cell is always enabled and the gate bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | Primary reference source, one-cycle tick per period |
| alt_tick | input | 8 | Secondary sources, one-cycle tick per period each |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| clk_pulse | output | 1 | One-cycle strobe at the start of each output period |
| clk_level | output | 1 | Output clock level |

## Verification
The assertions take for granted that every source tick is high for a single system clock cycle. They also take for granted that software writes a source index of at most 8, because larger values fold into the 3-bit select field. The stimulus generates each tick as a one-cycle strobe at a fixed period. The periods are prime, so a measured output period identifies both the source and the ratio. Every index the stimulus writes lies in the range 0 to 8.

// File: rtl/csd_pkg.sv
package csd_pkg;

  localparam int RAT_W  = 4;
  localparam int CODE_W = 3;

  typedef logic [RAT_W-1:0] ratio_t;

  function automatic ratio_t ratio_of(input logic [CODE_W-1:0] code);
    ratio_t r;
    case (code)
      3'd1:    r = 4'd2;
      3'd2:    r = 4'd4;
      3'd3:    r = 4'd6;
      3'd4:    r = 4'd8;
      3'd5:    r = 4'd12;
      default: r = 4'd1;
    endcase
    return r;
  endfunction

  // number of source periods the level stays high within one output period
  function automatic ratio_t high_len(input ratio_t r);
    ratio_t h;
    if (r == 4'd1 || r == 4'd3) h = 4'd1;
    else                        h = r >> 1;
    return h;
  endfunction

endpackage

// File: rtl/csd_regs.sv
module csd_regs
  import csd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int SEL_W    = 3,
  parameter bit HAS_MUX  = 1'b1,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              src_sw,
  output logic [SEL_W-1:0]  src_sel,
  output logic              div_sw,
  output logic              d3_sw,
  output logic [CODE_W-1:0] code,
  output logic              gate_on
);

  localparam int IDX_W = SEL_W + 1;
  localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(2);

  logic              wr_src, wr_div, wr_gate;
  logic              div_sw_q, d3_sw_q;
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  idx_rd;

  assign wr_src  = wr && (addr == A_SRC);
  assign wr_div  = wr && (addr == A_DIV);
  assign wr_gate = wr && (addr == A_GATE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_sw_q <= 1'b0;
      d3_sw_q  <= 1'b0;
      code_q   <= '0;
    end else if (wr_div) begin
      div_sw_q <= wdata[0];
      d3_sw_q  <= wdata[1];
      code_q   <= wdata[4 +: CODE_W];
    end
  end

  assign div_sw = div_sw_q;
  assign d3_sw  = d3_sw_q;
  assign code   = code_q;

  generate
    if (HAS_MUX) begin : g_mux
      logic             sw_q, sw_d;
      logic [SEL_W-1:0] sel_q, sel_d;
      logic [IDX_W-1:0] idx_wr, idx_m1;

      always_comb begin
        idx_wr = wdata[IDX_W-1:0];
        idx_m1 = idx_wr - 1'b1;
        sw_d   = sw_q;
        sel_d  = sel_q;
        if (wr_src) begin
          sw_d = (idx_wr != '0);
          if (idx_wr != '0) sel_d = idx_m1[SEL_W-1:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sw_q  <= 1'b0;
          sel_q <= '0;
        end else begin
          sw_q  <= sw_d;
          sel_q <= sel_d;
        end
      end

      assign src_sw  = sw_q;
      assign src_sel = sel_q;
      assign idx_rd  = sw_q ? ({1'b0, sel_q} + 1'b1) : '0;
    end else begin : g_nomux
      assign src_sw  = 1'b0;
      assign src_sel = '0;
      assign idx_rd  = '0;
    end

    if (HAS_GATE) begin : g_gate
      logic gate_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gate_q <= 1'b0;
        else if (wr_gate) gate_q <= wdata[0];
      end
      assign gate_on = gate_q;
    end else begin : g_nogate
      assign gate_on = 1'b1;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (addr)
      A_SRC:  rdata[IDX_W-1:0] = idx_rd;
      A_DIV:  begin
        rdata[0]            = div_sw_q;
        rdata[1]            = d3_sw_q;
        rdata[4 +: CODE_W]  = code_q;
      end
      A_GATE: rdata[0] = gate_on;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/csd_srcmux.sv
module csd_srcmux #(
  parameter int SEL_W   = 3,
  parameter bit HAS_MUX = 1'b1
) (
  input  logic                  ref_tick,
  input  logic [(1<<SEL_W)-1:0] alt_tick,
  input  logic                  src_sw,
  input  logic [SEL_W-1:0]      src_sel,
  output logic                  sel_tick
);

  generate
    if (HAS_MUX) begin : g_two_level
      logic alt_pick;
      assign alt_pick = alt_tick[src_sel];
      assign sel_tick = src_sw ? alt_pick : ref_tick;
    end else begin : g_fixed
      assign sel_tick = ref_tick;
    end
  endgenerate

endmodule

// File: rtl/csd_div.sv
module csd_div
  import csd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              div_sw,
  input  logic              d3_sw,
  input  logic [CODE_W-1:0] code,
  output logic              pulse,
  output logic              phase,
  output ratio_t            cnt,
  output ratio_t            ratio
);

  ratio_t ratio_nxt, ratio_q, ratio_use, cnt_q, cnt_d;
  logic   pulse_q, pulse_d, phase_q, phase_d;
  logic   at_bound, load_en;

  always_comb begin
    if (d3_sw)       ratio_nxt = 4'd3;
    else if (!div_sw) ratio_nxt = 4'd1;
    else             ratio_nxt = ratio_of(code);
  end

  assign at_bound  = (cnt_q == '0);
  assign load_en   = tick && at_bound;
  assign ratio_use = at_bound ? ratio_nxt : ratio_q;

  always_comb begin
    cnt_d   = cnt_q;
    phase_d = phase_q;
    pulse_d = 1'b0;
    if (tick) begin
      pulse_d = at_bound;
      phase_d = (cnt_q < high_len(ratio_use));
      cnt_d   = (cnt_q == ratio_use - 1'b1) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ratio_q <= 4'd1;
    else if (load_en) ratio_q <= ratio_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
      phase_q <= phase_d;
    end
  end

  assign pulse = pulse_q;
  assign phase = phase_q;
  assign cnt   = cnt_q;
  assign ratio = ratio_q;

endmodule

// File: rtl/clk_seldiv_cell.sv
module clk_seldiv_cell
  import csd_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int SEL_W    = 3,
  parameter bit HAS_MUX  = 1'b1,
  parameter bit HAS_GATE = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ref_tick,
  input  logic [(1<<SEL_W)-1:0] alt_tick,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  clk_pulse,
  output logic                  clk_level
);

  localparam int IDX_W = SEL_W + 1;

  logic              rst_meta, rst_sync_n;
  logic              src_sw, div_sw, d3_sw, gate_on, sel_tick;
  logic [SEL_W-1:0]  src_sel;
  logic [CODE_W-1:0] code;
  logic              div_pulse, div_phase;
  ratio_t            div_cnt, div_ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  csd_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
    .HAS_MUX(HAS_MUX), .HAS_GATE(HAS_GATE)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .src_sw(src_sw),
    .src_sel(src_sel), .div_sw(div_sw), .d3_sw(d3_sw), .code(code),
    .gate_on(gate_on)
  );

  csd_srcmux #(.SEL_W(SEL_W), .HAS_MUX(HAS_MUX)) u_mux (
    .ref_tick(ref_tick), .alt_tick(alt_tick), .src_sw(src_sw),
    .src_sel(src_sel), .sel_tick(sel_tick)
  );

  csd_div u_div (
    .clk(clk), .rst_n(rst_sync_n), .tick(sel_tick), .div_sw(div_sw),
    .d3_sw(d3_sw), .code(code), .pulse(div_pulse), .phase(div_phase),
    .cnt(div_cnt), .ratio(div_ratio)
  );

  assign clk_pulse = div_pulse & gate_on;
  assign clk_level = div_phase & gate_on;

endmodule

// File: rtl/clk_seldiv_cell_chk.sv
module clk_seldiv_cell_chk #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              src_sw,
  input logic              sel_tick,
  input logic              div_sw,
  input logic              d3_sw,
  input logic              gate_on,
  input logic [3:0]        div_cnt,
  input logic [3:0]        div_ratio,
  input logic              clk_pulse,
  input logic              clk_level
);

  AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gate_on |-> (!clk_pulse && !clk_level)); // R7

  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clk_pulse |-> $past(sel_tick)); // R3

  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_ratio inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12}); // R3

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_cnt < div_ratio); // R8

  AST_DIV3_WINS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_tick && div_cnt == 4'd0 && d3_sw) |=> (div_ratio == 4'd3)); // R4

  AST_BYPASS_ONE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel_tick && div_cnt == 4'd0 && !d3_sw && !div_sw) |=> (div_ratio == 4'd1)); // R5

  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(sel_tick && div_cnt == 4'd0) |=> $stable(div_ratio)); // R8

  AST_IDX0_REF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_wr && reg_addr == '0 && reg_wdata[IDX_W-1:0] == '0) |=> !src_sw); // R1

endmodule

bind clk_seldiv_cell clk_seldiv_cell_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .src_sw(src_sw), .sel_tick(sel_tick),
  .div_sw(div_sw), .d3_sw(d3_sw), .gate_on(gate_on), .div_cnt(div_cnt),
  .div_ratio(div_ratio), .clk_pulse(clk_pulse), .clk_level(clk_level)
);

// File: tb/clk_seldiv_cell_tb.sv
`timescale 1ns/1ps
module clk_seldiv_cell_tb;

  logic       clk, rst_n, ref_tick, reg_wr;
  logic [7:0] alt_tick, reg_wdata, rdata_a, rdata_b;
  logic [1:0] reg_addr;
  logic       pulse_a, level_a, pulse_b, level_b;
  int         n_checks, n_errors;
  bit         done;

  int per_src [9] = '{5, 7, 11, 13, 17, 19, 23, 29, 31};
  int ratio_tab [8] = '{1, 2, 4, 6, 8, 12, 1, 1};

  clk_seldiv_cell u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alt_tick(alt_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_a), .clk_pulse(pulse_a), .clk_level(level_a)
  );

  clk_seldiv_cell #(.HAS_MUX(1'b0), .HAS_GATE(1'b0)) u_fixed (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alt_tick(alt_tick),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_b), .clk_pulse(pulse_b), .clk_level(level_b)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    int c [9];
    for (int i = 0; i < 9; i++) c[i] = 0;
    ref_tick = 1'b0;
    alt_tick = '0;
    forever begin
      @(posedge clk);
      for (int i = 0; i < 9; i++) c[i] = (c[i] == per_src[i] - 1) ? 0 : c[i] + 1;
      ref_tick <= (c[0] == 0);
      for (int i = 1; i < 9; i++) alt_tick[i-1] <= (c[i] == 0);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int va, output int vb);
    @(negedge clk);
    reg_addr = a;
    #1;
    va = rdata_a;
    vb = rdata_b;
  endtask

  function automatic bit pl(input bit fx);
    return fx ? pulse_b : pulse_a;
  endfunction

  task automatic wait_pulse(input bit fx);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pl(fx) && n < 3000);
  endtask

  task automatic period(input bit fx, output int cyc);
    wait_pulse(fx);
    wait_pulse(fx);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!pl(fx) && cyc < 3000);
  endtask

  task automatic t_reset();
    int a, b, np;
    for (int r = 0; r < 3; r++) begin
      rd(r[1:0], a, b);
      check($sformatf("R9 reset read addr %0d", r), a, 0);
    end
    rd(2'd2, a, b);
    check("R10 fixed gate reads 1", b, 1);
    np = 0;
    repeat (200) begin
      @(negedge clk);
      if (pulse_a) np++;
    end
    check("R9 no pulse after reset", np, 0);
  endtask

  task automatic t_readback();
    int a, b;
    for (int n = 0; n <= 8; n++) begin
      wr(2'd0, 8'(n));
      rd(2'd0, a, b);
      check($sformatf("R2 index readback %0d", n), a, n);
      if (n == 3) check("R10 fixed index reads 0", b, 0);
    end
  endtask

  task automatic t_table();
    int cyc;
    wr(2'd2, 8'd1);
    wr(2'd0, 8'd0);
    for (int k = 0; k < 8; k++) begin
      wr(2'd1, 8'((k << 4) | 1));
      period(1'b0, cyc);
      check($sformatf("R3 code %0d period", k), cyc, ratio_tab[k] * 5);
    end
  endtask

  task automatic t_bypass();
    int cyc, lowc;
    wr(2'd1, 8'((5 << 4) | 0));
    period(1'b0, cyc);
    check("R5 divider off ratio 1", cyc, 5);
    lowc = 0;
    repeat (50) begin
      @(negedge clk);
      if (!level_a) lowc++;
    end
    check("R5 level stays high", lowc, 0);
  endtask

  task automatic t_div3();
    int cyc, h;
    for (int v = 0; v < 4; v++) begin
      int code = (v[1]) ? 5 : 0;
      wr(2'd1, 8'((code << 4) | 2 | v[0]));
      period(1'b0, cyc);
      check($sformatf("R4 div3 code %0d sw %0d", code, v[0]), cyc, 15);
    end
    h = 0;
    while (level_a && h < 100) begin
      h++;
      @(negedge clk);
    end
    check("R4 div3 high one period", h, 5);
  endtask

  task automatic t_duty();
    int cyc, h;
    int codes [2] = '{2, 5};
    for (int i = 0; i < 2; i++) begin
      wr(2'd1, 8'((codes[i] << 4) | 1));
      period(1'b0, cyc);
      h = 0;
      while (level_a && h < 200) begin
        h++;
        @(negedge clk);
      end
      check($sformatf("R6 duty code %0d", codes[i]), h * 2, cyc);
    end
  endtask

  task automatic t_sources();
    int cyc;
    wr(2'd1, 8'((1 << 4) | 1));
    for (int n = 1; n <= 8; n++) begin
      wr(2'd0, 8'(n));
      period(1'b0, cyc);
      check($sformatf("R1 source index %0d", n), cyc, 2 * per_src[n]);
      if (n == 3) begin
        period(1'b1, cyc);
        check("R10 fixed unit stays on reference", cyc, 10);
      end
    end
    wr(2'd0, 8'd0);
    period(1'b0, cyc);
    check("R1 index 0 reference", cyc, 10);
  endtask

  task automatic t_gate();
    int a, b, seen;
    wr(2'd2, 8'd0);
    rd(2'd2, a, b);
    check("R7 gate reads 0", a, 0);
    seen = 0;
    repeat (400) begin
      @(negedge clk);
      if (pulse_a || level_a) seen++;
    end
    check("R7 output held low", seen, 0);
    wr(2'd2, 8'd1);
    rd(2'd2, a, b);
    check("R7 gate reads 1", a, 1);
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (pulse_a) seen++;
    end
    check("R7 output passes", seen > 0, 1);
  endtask

  task automatic t_boundary();
    int n;
    wr(2'd0, 8'd0);
    wr(2'd1, 8'((5 << 4) | 1));
    wait_pulse(1'b0);
    wait_pulse(1'b0);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 8'((1 << 4) | 1);
    n = 0;
    do begin
      @(negedge clk);
      reg_wr = 1'b0;
      n++;
    end while (!pulse_a && n < 3000);
    check("R8 running period keeps old ratio", n, 60);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pulse_a && n < 3000);
    check("R8 new ratio after boundary", n, 10);
  endtask

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_table();
    t_bypass();
    t_div3();
    t_duty();
    t_sources();
    t_gate();
    t_boundary();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule